// File: doc/BRIEF.md
# Memory Access Fault Checker

This block decides whether a memory access that has already been through the table walk may go ahead, and if not, which fault it raises. A request carries the virtual address, the access size, the direction, whether it is an instruction fetch, the privilege level, and the walker's result: section or page mapping, page kind, the packed access-permission fields, the domain number and a translation-fault flag. The domain access control word and the global controls are sampled with it: translation enable, alignment-check enable, and the system and ROM protection bits.

A sequencer walks the checks in a fixed order and stops at the first failure. States: `ST_IDLE` waits for `req_vld` and latches the request (IDLE→ALIGN). `ST_ALIGN` checks alignment (→FAULT on a misaligned data access, →GRANT when translation is off, else →XLATE). `ST_XLATE` checks the walker flag (→FAULT or →DOMAIN). `ST_DOMAIN` reads the domain field (no access or reserved →FAULT, manager →GRANT, client →PERM). `ST_PERM` applies the permission rule to the selected field (→FAULT or →GRANT). `ST_FAULT` and `ST_GRANT` each present the response for one cycle and return to `ST_IDLE`. A `req_vld` seen outside `ST_IDLE` is not taken.

On a data-side fault the block records the status code and domain number in a fault status register and the virtual address in a fault address register. Faults on instruction fetches are reported on the response but leave both registers untouched.

Top module: `mmu_access_guard`

## Requirements
- R1: With `align_chk`=1, a data access with `acc_size`=2'b10 (word) and `va[1:0]`≠0, or `acc_size`=2'b01 (halfword) and `va[0]`=1, aborts with status 4'b0001; a byte access (2'b00) and any fetch (`is_fetch`=1) never raise this fault.
- R2: An alignment fault is reported even when the translation flag, domain or permissions would also fail; no later check changes its status.
- R3: With `mmu_on`=0 no translation, domain or permission fault is raised; an access that is not misaligned is granted.
- R4: With `xlat_fault`=1 the status is 4'b0101 for a section (`is_page`=0) and 4'b0111 for a page, ahead of any domain or permission result.
- R5: The domain field for domain d is `dacr[2d+1:2d]`; values 2'b00 and 2'b10 abort with 4'b1001 (section) or 4'b1011 (page).
- R6: Domain value 2'b11 (manager) grants the access whatever the permission fields hold.
- R7: Domain value 2'b01 (client) applies the permission rule: 2'b11 allows all; 2'b10 allows privileged accesses and user reads; 2'b01 allows privileged accesses only; 2'b00 allows reads only, to privileged code when `sys_prot`=1 and to all when `rom_prot`=1. A section uses `ap_field[1:0]`; a denied section access aborts with 4'b1101.
- R8: Permission field n sits at `ap_field[2n+1:2n]`. A small page (`page_kind`=2'b01) selects n from `va[11:10]`, a large page (2'b00) from `va[15:14]`, a tiny page (2'b10) uses field 0; a denied page access aborts with 4'b1111.
- R9: A fault with `is_fetch`=0 loads `fsr_status` with the status, `fsr_domain` with the domain number and `far` with the virtual address, one cycle after the response; fetch faults and grants leave all three unchanged.
- R10: After reset `rsp_vld`, `abort`, `fault_status`, `fsr_status`, `fsr_domain` and `far` are 0; each request gets exactly one single-cycle `rsp_vld` pulse within five cycles, and `abort` is high only with `rsp_vld`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_vld | input | 1 | Request strobe, taken in idle |
| va | input | 32 | Virtual address |
| acc_size | input | 2 | 00 byte, 01 halfword, 10 word |
| is_write | input | 1 | Write access |
| is_fetch | input | 1 | Instruction fetch |
| is_priv | input | 1 | Privileged access |
| is_page | input | 1 | Page mapping (0 = section) |
| page_kind | input | 2 | 00 large, 01 small, 10 tiny |
| ap_field | input | 8 | Packed permission fields |
| domain_id | input | 4 | Domain number |
| xlat_fault | input | 1 | Walker found an invalid descriptor |
| dacr | input | 32 | Domain access control word |
| mmu_on | input | 1 | Translation enable |
| align_chk | input | 1 | Alignment check enable |
| sys_prot | input | 1 | System protection control |
| rom_prot | input | 1 | ROM protection control |
| rsp_vld | output | 1 | Response valid pulse |
| abort | output | 1 | Access aborted |
| fault_status | output | 4 | Fault code of the response |
| fsr_status | output | 4 | Recorded data fault code |
| fsr_domain | output | 4 | Recorded data fault domain |
| far | output | 32 | Recorded data fault address |

## Verification
The hardest outcome to reach is a subpage permission fault on a chosen quarter of a page: it needs translation on, no alignment or translation failure, a client domain selected out of the 32-bit control word, and a denying field in exactly the slot picked by the page-kind-dependent address bits. Directed cases build that path by placing a client value at the chosen domain slot and a lone denying field at each slot index, stepping `va[11:10]` and `va[15:14]`; a long constrained-random run with a fixed seed then mixes precedence collisions, fetch-side faults between data faults, and the read-only rule under each protection-bit pairing.

// File: rtl/mmu_guard_pkg.sv
package mmu_guard_pkg;

    typedef enum logic [1:0] {
        SZ_BYTE = 2'b00,
        SZ_HALF = 2'b01,
        SZ_WORD = 2'b10,
        SZ_RSVD = 2'b11
    } acc_size_e;

    typedef enum logic [1:0] {
        PG_LARGE = 2'b00,
        PG_SMALL = 2'b01,
        PG_TINY  = 2'b10,
        PG_RSVD  = 2'b11
    } page_kind_e;

    typedef enum logic [1:0] {
        DOM_NONE    = 2'b00,
        DOM_CLIENT  = 2'b01,
        DOM_RSVD    = 2'b10,
        DOM_MANAGER = 2'b11
    } dom_mode_e;

    typedef enum logic [2:0] {
        ST_IDLE   = 3'd0,
        ST_ALIGN  = 3'd1,
        ST_XLATE  = 3'd2,
        ST_DOMAIN = 3'd3,
        ST_PERM   = 3'd4,
        ST_FAULT  = 3'd5,
        ST_GRANT  = 3'd6
    } chk_state_e;

    localparam logic [3:0] FS_NONE      = 4'b0000;
    localparam logic [3:0] FS_ALIGN     = 4'b0001;
    localparam logic [3:0] FS_XL_SEC    = 4'b0101;
    localparam logic [3:0] FS_XL_PAGE   = 4'b0111;
    localparam logic [3:0] FS_DOM_SEC   = 4'b1001;
    localparam logic [3:0] FS_DOM_PAGE  = 4'b1011;
    localparam logic [3:0] FS_PERM_SEC  = 4'b1101;
    localparam logic [3:0] FS_PERM_PAGE = 4'b1111;

endpackage

// File: rtl/mag_ap_pick.sv
module mag_ap_pick
    import mmu_guard_pkg::*;
#(
    parameter int AP_N = 4,
    parameter int AP_W = 2,
    localparam int IDX_W = $clog2(AP_N),
    localparam int APF_W = AP_N * AP_W
) (
    input  logic               is_page,
    input  page_kind_e         kind,
    input  logic [APF_W-1:0]   ap_field,
    input  logic [IDX_W-1:0]   small_idx,
    input  logic [IDX_W-1:0]   large_idx,
    output logic [AP_W-1:0]    ap_sel
);

    logic [AP_W-1:0]  slot [AP_N];
    logic [IDX_W-1:0] idx;

    for (genvar g = 0; g < AP_N; g++) begin : g_slot
        assign slot[g] = ap_field[g*AP_W +: AP_W];
    end

    always_comb begin
        idx = '0;
        if (is_page) begin
            unique case (kind)
                PG_SMALL: idx = small_idx;
                PG_LARGE: idx = large_idx;
                default:  idx = '0;
            endcase
        end
        ap_sel = slot[idx];
    end

endmodule

// File: rtl/mag_ap_rule.sv
module mag_ap_rule (
    input  logic [1:0] ap,
    input  logic       is_write,
    input  logic       is_priv,
    input  logic       sys_prot,
    input  logic       rom_prot,
    output logic       allow
);

    always_comb begin
        unique case (ap)
            2'b11:   allow = 1'b1;
            2'b10:   allow = is_priv | ~is_write;
            2'b01:   allow = is_priv;
            default: allow = ~is_write & ((sys_prot & is_priv) | rom_prot);
        endcase
    end

endmodule

// File: rtl/mag_dom_lookup.sv
module mag_dom_lookup
    import mmu_guard_pkg::*;
#(
    parameter int DOM_N = 16,
    localparam int DOM_IDX_W = $clog2(DOM_N),
    localparam int DACR_W = 2 * DOM_N
) (
    input  logic [DACR_W-1:0]    dacr,
    input  logic [DOM_IDX_W-1:0] dom_id,
    output dom_mode_e            mode
);

    logic [1:0] field [DOM_N];

    for (genvar g = 0; g < DOM_N; g++) begin : g_field
        assign field[g] = dacr[2*g +: 2];
    end

    assign mode = dom_mode_e'(field[dom_id]);

endmodule

// File: rtl/mmu_access_guard.sv
module mmu_access_guard
    import mmu_guard_pkg::*;
#(
    parameter int VA_W  = 32,
    parameter int DOM_N = 16,
    parameter int AP_N  = 4,
    parameter int SMALL_SEL_LSB = 10,
    parameter int LARGE_SEL_LSB = 14,
    localparam int DOM_IDX_W = $clog2(DOM_N),
    localparam int DACR_W    = 2 * DOM_N,
    localparam int APF_W     = 2 * AP_N,
    localparam int IDX_W     = $clog2(AP_N)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 req_vld,
    input  logic [VA_W-1:0]      va,
    input  logic [1:0]           acc_size,
    input  logic                 is_write,
    input  logic                 is_fetch,
    input  logic                 is_priv,
    input  logic                 is_page,
    input  logic [1:0]           page_kind,
    input  logic [APF_W-1:0]     ap_field,
    input  logic [DOM_IDX_W-1:0] domain_id,
    input  logic                 xlat_fault,
    input  logic [DACR_W-1:0]    dacr,
    input  logic                 mmu_on,
    input  logic                 align_chk,
    input  logic                 sys_prot,
    input  logic                 rom_prot,
    output logic                 rsp_vld,
    output logic                 abort,
    output logic [3:0]           fault_status,
    output logic [3:0]           fsr_status,
    output logic [DOM_IDX_W-1:0] fsr_domain,
    output logic [VA_W-1:0]      far
);

    chk_state_e state, nxt;

    // latched request
    logic [VA_W-1:0]      va_q;
    acc_size_e            size_q;
    logic                 write_q, fetch_q, priv_q, page_q, xf_q;
    page_kind_e           kind_q;
    logic [APF_W-1:0]     apf_q;
    logic [DOM_IDX_W-1:0] dom_q;
    logic [DACR_W-1:0]    dacr_q;
    logic                 mmu_q, alc_q, sys_q, rom_q;

    logic [3:0] code_q, code_n;
    logic       take;
    logic       misaligned, align_flt;
    logic [1:0] ap_sel;
    logic       allow;
    dom_mode_e  dom_mode;

    assign take = (state == ST_IDLE) && req_vld;

    mag_ap_pick #(
        .AP_N (AP_N),
        .AP_W (2)
    ) u_pick (
        .is_page   (page_q),
        .kind      (kind_q),
        .ap_field  (apf_q),
        .small_idx (va_q[SMALL_SEL_LSB +: IDX_W]),
        .large_idx (va_q[LARGE_SEL_LSB +: IDX_W]),
        .ap_sel    (ap_sel)
    );

    mag_ap_rule u_rule (
        .ap       (ap_sel),
        .is_write (write_q),
        .is_priv  (priv_q),
        .sys_prot (sys_q),
        .rom_prot (rom_q),
        .allow    (allow)
    );

    mag_dom_lookup #(
        .DOM_N (DOM_N)
    ) u_dom (
        .dacr   (dacr_q),
        .dom_id (dom_q),
        .mode   (dom_mode)
    );

    always_comb begin
        unique case (size_q)
            SZ_WORD: misaligned = (va_q[1:0] != 2'b00);
            SZ_HALF: misaligned = va_q[0];
            default: misaligned = 1'b0;
        endcase
        align_flt = alc_q & ~fetch_q & misaligned;
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= ST_IDLE;
        end else begin
            state <= nxt;
        end
    end

    // next state and fault code selection
    always_comb begin
        nxt    = state;
        code_n = code_q;
        unique case (state)
            ST_IDLE: begin
                if (req_vld) begin
                    nxt    = ST_ALIGN;
                    code_n = FS_NONE;
                end
            end
            ST_ALIGN: begin
                if (align_flt) begin
                    nxt    = ST_FAULT;
                    code_n = FS_ALIGN;
                end else if (!mmu_q) begin
                    nxt = ST_GRANT;
                end else begin
                    nxt = ST_XLATE;
                end
            end
            ST_XLATE: begin
                if (xf_q) begin
                    nxt    = ST_FAULT;
                    code_n = page_q ? FS_XL_PAGE : FS_XL_SEC;
                end else begin
                    nxt = ST_DOMAIN;
                end
            end
            ST_DOMAIN: begin
                unique case (dom_mode)
                    DOM_CLIENT:  nxt = ST_PERM;
                    DOM_MANAGER: nxt = ST_GRANT;
                    default: begin
                        nxt    = ST_FAULT;
                        code_n = page_q ? FS_DOM_PAGE : FS_DOM_SEC;
                    end
                endcase
            end
            ST_PERM: begin
                if (allow) begin
                    nxt = ST_GRANT;
                end else begin
                    nxt    = ST_FAULT;
                    code_n = page_q ? FS_PERM_PAGE : FS_PERM_SEC;
                end
            end
            ST_FAULT: nxt = ST_IDLE;
            ST_GRANT: nxt = ST_IDLE;
            default:  nxt = ST_IDLE;
        endcase
    end

    // request latch, fault code and fault registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            va_q       <= '0;
            size_q     <= SZ_BYTE;
            write_q    <= 1'b0;
            fetch_q    <= 1'b0;
            priv_q     <= 1'b0;
            page_q     <= 1'b0;
            kind_q     <= PG_LARGE;
            apf_q      <= '0;
            dom_q      <= '0;
            xf_q       <= 1'b0;
            dacr_q     <= '0;
            mmu_q      <= 1'b0;
            alc_q      <= 1'b0;
            sys_q      <= 1'b0;
            rom_q      <= 1'b0;
            code_q     <= FS_NONE;
            fsr_status <= FS_NONE;
            fsr_domain <= '0;
            far        <= '0;
        end else begin
            code_q <= code_n;
            if (take) begin
                va_q    <= va;
                size_q  <= acc_size_e'(acc_size);
                write_q <= is_write;
                fetch_q <= is_fetch;
                priv_q  <= is_priv;
                page_q  <= is_page;
                kind_q  <= page_kind_e'(page_kind);
                apf_q   <= ap_field;
                dom_q   <= domain_id;
                xf_q    <= xlat_fault;
                dacr_q  <= dacr;
                mmu_q   <= mmu_on;
                alc_q   <= align_chk;
                sys_q   <= sys_prot;
                rom_q   <= rom_prot;
            end
            if ((state == ST_FAULT) && !fetch_q) begin
                fsr_status <= code_q;
                fsr_domain <= dom_q;
                far        <= va_q;
            end
        end
    end

    // outputs
    always_comb begin
        rsp_vld      = 1'b0;
        abort        = 1'b0;
        fault_status = FS_NONE;
        unique case (state)
            ST_FAULT: begin
                rsp_vld      = 1'b1;
                abort        = 1'b1;
                fault_status = code_q;
            end
            ST_GRANT: rsp_vld = 1'b1;
            default: ;
        endcase
    end

endmodule

// File: rtl/mmu_access_guard_chk.sv
module mmu_access_guard_chk
    import mmu_guard_pkg::*;
#(
    parameter int VA_W = 32,
    parameter int DOM_IDX_W = 4
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 rsp_vld,
    input logic                 abort,
    input logic [3:0]           fault_status,
    input logic [3:0]           fsr_status,
    input logic [DOM_IDX_W-1:0] fsr_domain,
    input logic [VA_W-1:0]      far,
    input logic                 fetch_q,
    input logic                 mmu_q,
    input logic [VA_W-1:0]      va_q,
    input dom_mode_e            dom_mode
);

    assert_abort_qual_R10: assert property (@(posedge clk) disable iff (!rst_n)
        abort |-> rsp_vld);

    assert_single_pulse_R10: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_vld |=> !rsp_vld);

    assert_align_data_only_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_vld && abort && fault_status == FS_ALIGN) |-> !fetch_q);

    assert_off_no_mmu_fault_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_vld && abort && !mmu_q) |-> (fault_status == FS_ALIGN));

    assert_perm_needs_client_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_vld && abort && (fault_status == FS_PERM_SEC || fault_status == FS_PERM_PAGE))
            |-> (dom_mode == DOM_CLIENT));

    assert_far_capture_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_vld && abort && !fetch_q) |=> (far == $past(va_q) && fsr_status == $past(fault_status)));

    assert_regs_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !(rsp_vld && abort && !fetch_q) |=> ($stable(far) && $stable(fsr_status) && $stable(fsr_domain)));

endmodule

bind mmu_access_guard mmu_access_guard_chk #(
    .VA_W      (VA_W),
    .DOM_IDX_W (DOM_IDX_W)
) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .rsp_vld      (rsp_vld),
    .abort        (abort),
    .fault_status (fault_status),
    .fsr_status   (fsr_status),
    .fsr_domain   (fsr_domain),
    .far          (far),
    .fetch_q      (fetch_q),
    .mmu_q        (mmu_q),
    .va_q         (va_q),
    .dom_mode     (dom_mode)
);

// File: tb/mmu_access_guard_tb_top.sv
module mmu_access_guard_tb_top;

    typedef struct {
        logic [31:0] va;
        logic [1:0]  size;
        logic        wr, fetch, priv, page;
        logic [1:0]  kind;
        logic [7:0]  apf;
        logic [3:0]  dom;
        logic        xf;
        logic [31:0] dacr;
        logic        mmu, alc, s, r;
    } stim_t;

    localparam int WATCHDOG = 150000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_vld = 1'b0;
    logic [31:0] va = '0;
    logic [1:0]  acc_size = '0;
    logic        is_write = 1'b0, is_fetch = 1'b0, is_priv = 1'b0, is_page = 1'b0;
    logic [1:0]  page_kind = '0;
    logic [7:0]  ap_field = '0;
    logic [3:0]  domain_id = '0;
    logic        xlat_fault = 1'b0;
    logic [31:0] dacr = '0;
    logic        mmu_on = 1'b0, align_chk = 1'b0, sys_prot = 1'b0, rom_prot = 1'b0;
    logic        rsp_vld, abort;
    logic [3:0]  fault_status, fsr_status, fsr_domain;
    logic [31:0] far;

    int total = 0;
    int bad = 0;
    int cycles = 0;
    logic [3:0]  m_fsr = '0;
    logic [3:0]  m_dom = '0;
    logic [31:0] m_far = '0;

    always #2 clk = ~clk;

    mmu_access_guard dut_i (
        .clk(clk), .rst_n(rst_n), .req_vld(req_vld), .va(va), .acc_size(acc_size),
        .is_write(is_write), .is_fetch(is_fetch), .is_priv(is_priv), .is_page(is_page),
        .page_kind(page_kind), .ap_field(ap_field), .domain_id(domain_id),
        .xlat_fault(xlat_fault), .dacr(dacr), .mmu_on(mmu_on), .align_chk(align_chk),
        .sys_prot(sys_prot), .rom_prot(rom_prot), .rsp_vld(rsp_vld), .abort(abort),
        .fault_status(fault_status), .fsr_status(fsr_status), .fsr_domain(fsr_domain),
        .far(far)
    );

    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles >= WATCHDOG) begin
            bad   = bad + 1;
            total = total + 1;
            $display("FAIL watchdog: run hung, actual=%0d cycles expected<%0d", cycles, WATCHDOG);
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    function automatic string tag_of(input logic [4:0] e);
        case (e[3:0])
            4'b0001: return "R1";
            4'b0101, 4'b0111: return "R4";
            4'b1001, 4'b1011: return "R5";
            4'b1101: return "R7";
            4'b1111: return "R8";
            default: return "R6";
        endcase
    endfunction

    function automatic logic ap_ok(input logic [1:0] ap, input stim_t t);
        case (ap)
            2'b11: return 1'b1;
            2'b10: return t.priv || !t.wr;
            2'b01: return t.priv;
            default: return !t.wr && ((t.s && t.priv) || t.r);
        endcase
    endfunction

    // returns {abort, status}
    function automatic logic [4:0] model(input stim_t t);
        logic mis;
        logic [1:0] dm, ap, idx;
        mis = (t.size == 2'b10 && t.va[1:0] != 0) || (t.size == 2'b01 && t.va[0]);
        if (t.alc && !t.fetch && mis) return 5'b1_0001;
        if (!t.mmu) return 5'b0_0000;
        if (t.xf) return t.page ? 5'b1_0111 : 5'b1_0101;
        dm = t.dacr[2*t.dom +: 2];
        if (dm == 2'b11) return 5'b0_0000;
        if (dm != 2'b01) return t.page ? 5'b1_1011 : 5'b1_1001;
        idx = 2'd0;
        if (t.page && t.kind == 2'b01) idx = t.va[11:10];
        if (t.page && t.kind == 2'b00) idx = t.va[15:14];
        ap = t.apf[2*idx +: 2];
        if (ap_ok(ap, t)) return 5'b0_0000;
        return t.page ? 5'b1_1111 : 5'b1_1101;
    endfunction

    task automatic check(input logic ok, input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        total = total + 1;
        if (!ok) begin
            bad = bad + 1;
            $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    task automatic run(input stim_t t, input string req);
        logic [4:0] e;
        int n;
        e = model(t);
        @(negedge clk);
        va = t.va; acc_size = t.size; is_write = t.wr; is_fetch = t.fetch;
        is_priv = t.priv; is_page = t.page; page_kind = t.kind; ap_field = t.apf;
        domain_id = t.dom; xlat_fault = t.xf; dacr = t.dacr; mmu_on = t.mmu;
        align_chk = t.alc; sys_prot = t.s; rom_prot = t.r;
        req_vld = 1'b1;
        @(negedge clk);
        req_vld = 1'b0;
        n = 0;
        while (!rsp_vld && n < 10) begin
            @(negedge clk);
            n++;
        end
        // R10: response within five cycles
        check(n < 5, "R10", "response latency", n, 5);
        check({abort, fault_status} == e, req, "abort/status", {abort, fault_status}, e);
        if (e[4] && !t.fetch) begin
            m_fsr = e[3:0]; m_dom = t.dom; m_far = t.va;
        end
        @(negedge clk);
        // R9: fault registers follow only data-side faults
        check(fsr_status == m_fsr && fsr_domain == m_dom && far == m_far, "R9", "fault regs",
              {20'd0, fsr_status, fsr_domain, 4'd0} ^ far, {20'd0, m_fsr, m_dom, 4'd0} ^ m_far);
        check(!rsp_vld, "R10", "pulse width", rsp_vld, 0);
    endtask

    function automatic stim_t base();
        stim_t t;
        t.va = 32'h0000_1000; t.size = 2'b10; t.wr = 1'b0; t.fetch = 1'b0; t.priv = 1'b1;
        t.page = 1'b0; t.kind = 2'b01; t.apf = 8'hFF; t.dom = 4'd3; t.xf = 1'b0;
        t.dacr = 32'h5555_5555; t.mmu = 1'b1; t.alc = 1'b1; t.s = 1'b0; t.r = 1'b0;
        return t;
    endfunction

    initial begin
        stim_t t;
        int unused_seed;
        unused_seed = $urandom(32'd7721);
        repeat (3) @(negedge clk);
        // R10: reset state
        check(!rsp_vld && !abort && fault_status == 0, "R10", "reset outputs",
              {rsp_vld, abort, fault_status}, 0);
        check(fsr_status == 0 && fsr_domain == 0 && far == 0, "R10", "reset regs", far, 0);
        rst_n = 1'b1;

        // R1: misaligned word and halfword, aligned byte, fetch
        t = base(); t.va = 32'h0000_1002; run(t, "R1");
        t = base(); t.size = 2'b01; t.va = 32'h0000_1003; run(t, "R1");
        t = base(); t.size = 2'b00; t.va = 32'h0000_1003; run(t, "R1");
        t = base(); t.fetch = 1'b1; t.va = 32'h0000_1001; run(t, "R1");
        t = base(); t.alc = 1'b0; t.va = 32'h0000_1001; run(t, "R1");
        // R2: alignment wins over translation, domain and permission
        t = base(); t.va = 32'h0000_2001; t.xf = 1'b1; t.dacr = 0; t.apf = 0; run(t, "R2");
        // R3: MMU off hides translation and domain faults
        t = base(); t.mmu = 1'b0; t.xf = 1'b1; t.dacr = 0; run(t, "R3");
        // R4: translation faults
        t = base(); t.xf = 1'b1; t.dacr = 0; run(t, "R4");
        t = base(); t.xf = 1'b1; t.page = 1'b1; run(t, "R4");
        // R5: no access and reserved domains
        t = base(); t.dacr = 32'h5555_5555 & ~(32'h3 << 6); run(t, "R5");
        t = base(); t.page = 1'b1; t.dacr = (32'h5555_5555 & ~(32'h3 << 6)) | (32'h2 << 6); run(t, "R5");
        // R6: manager ignores permission fields
        t = base(); t.dacr = 32'h0000_00C0; t.apf = 8'h00; t.wr = 1'b1; t.priv = 1'b0; run(t, "R6");
        // R7: section permission rules
        t = base(); t.apf = 8'h01; t.priv = 1'b0; run(t, "R7");
        t = base(); t.apf = 8'h02; t.priv = 1'b0; t.wr = 1'b1; run(t, "R7");
        t = base(); t.apf = 8'h00; t.s = 1'b1; run(t, "R7");
        t = base(); t.apf = 8'h00; t.s = 1'b1; t.priv = 1'b0; run(t, "R7");
        t = base(); t.apf = 8'h00; t.r = 1'b1; t.priv = 1'b0; run(t, "R7");
        // R8: subpage slot selection, one denying slot at a time
        for (int k = 0; k < 4; k++) begin
            for (int q = 0; q < 4; q++) begin
                t = base(); t.page = 1'b1; t.priv = 1'b0; t.wr = 1'b1;
                t.apf = 8'hFF & ~(8'h3 << (2*k));
                t.kind = 2'b01; t.va = 32'h0040_0000 | (q << 10); run(t, "R8");
                t.kind = 2'b00; t.va = 32'h0040_0000 | (q << 14); run(t, "R8");
            end
        end
        t = base(); t.page = 1'b1; t.kind = 2'b10; t.priv = 1'b0; t.apf = 8'hFC;
        t.va = 32'h0000_0C00; run(t, "R8");
        // R9: fetch fault after data fault leaves the registers
        t = base(); t.xf = 1'b1; t.va = 32'h1234_5678; run(t, "R9");
        t = base(); t.xf = 1'b1; t.fetch = 1'b1; t.va = 32'h8765_4320; run(t, "R9");

        // constrained random mix
        for (int i = 0; i < 1500; i++) begin
            t.va    = $urandom;
            t.size  = 2'($urandom_range(0, 2));
            t.wr    = 1'($urandom);
            t.fetch = ($urandom_range(0, 3) == 0);
            t.priv  = 1'($urandom);
            t.page  = 1'($urandom);
            t.kind  = 2'($urandom_range(0, 2));
            t.apf   = 8'($urandom);
            t.dom   = 4'($urandom);
            t.xf    = ($urandom_range(0, 7) == 0);
            t.dacr  = $urandom;
            t.mmu   = ($urandom_range(0, 9) != 0);
            t.alc   = 1'($urandom);
            t.s     = 1'($urandom);
            t.r     = 1'($urandom);
            run(t, tag_of(model(t)));
        end

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule